// File: doc/BRIEF.md
# Reference Phase-Step Absorbing Delay

This block sits between a reference selector and a digital phase-locked loop. It takes two reference pulse trains, primary and secondary, both sampled on the system clock. It picks one of them and produces a virtual reference pulse for the loop. The virtual reference is the selected reference delayed by a programmable number of system-clock ticks. The delay applies only while correction is enabled. With correction disabled, the selected reference passes with no added delay.

When the selection changes while correction is enabled, the block measures the lag in ticks from the next rising edge of the loop feedback to the next rising edge of the newly selected reference. It turns that lag into a delay that places the new reference's edges on the feedback phase. The loop is expected to be in holdover during the switch. The new delay is committed only once holdover is released, so the loop never sees a phase step. The rate code fixes the reference period in ticks. A reset is required after any change of that code.

Top module: `phase_step_absorber`

## Requirements
- R1: After reset, vref_pulse is 0, delay_val is 0 and meas_err is 0.
- R2: With tie_en low, delay_val reads 0. Each rising edge of the selected reference gives a one-cycle vref_pulse exactly 1 cycle after the clock edge that first samples it high.
- R3: With tie_en high and a committed delay D, each accepted rising edge of the selected reference gives a one-cycle vref_pulse exactly 1+D cycles after the clock edge that first samples it high, and delay_val reads D.
- R4: Only the reference chosen by ref_sel (0 = primary, 1 = secondary) produces vref_pulse. Edges on the other input have no effect.
- R5: When ref_sel changes with tie_en high, the block measures lag m. m is the number of cycles from the next sampled rising edge of fb_pulse to the next sampled rising edge of the newly selected reference, and is 0 if both edges arrive together. The delay to commit is 0 when m = 0 and P − m otherwise.
- R6: A measured delay is committed only in a cycle where holdover is low. While holdover stays high, delay_val keeps its previous value.
- R7: If no edge of the new reference arrives within P − 1 cycles after the feedback edge, meas_err goes to 1 and the delay is left unchanged. meas_err clears on the next switch or on delay_clr.
- R8: delay_clr sets the delay to 0 on the next cycle and cancels any measurement in progress, so nothing is committed afterwards.
- R9: The period P in ticks comes from freq_sel: 00 → PER_CODE0 (default 20), 01 → PER_CODE1 (200), 10 → PER_CODE2 (50), 11 → PER_CODE3 (64). The committed delay is always below P.
- R10: At most one edge is in flight in the delay stage. A selected-reference edge that arrives while an earlier one is still pending is dropped.
- R11: After a switch with a steady feedback train of period P, every vref_pulse falls exactly 1 cycle after a sampled feedback edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the unit of delay |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_sel | input | 1 | Reference choice: 0 primary, 1 secondary |
| pri_ref | input | 1 | Primary reference pulse train, clk-synchronous |
| sec_ref | input | 1 | Secondary reference pulse train, clk-synchronous |
| fb_pulse | input | 1 | Feedback pulse from the loop |
| tie_en | input | 1 | Enables phase-step correction |
| holdover | input | 1 | High while the loop ignores the virtual reference |
| freq_sel | input | 2 | Reference rate code |
| delay_clr | input | 1 | Clears the delay and cancels measurement |
| vref_pulse | output | 1 | Virtual reference pulse |
| delay_val | output | 12 | Delay currently applied, in ticks |
| meas_err | output | 1 | Measurement timed out without a reference edge |

## Verification
The assertions check on every cycle the properties that do not depend on a scenario. Output pulses last one cycle. The delay stays below the period, changes only after a clear or while holdover is low, and goes to zero after a clear. An error can only rise out of an active measurement. Only the bench scenarios can show the end-to-end timing. That covers the exact 1+D latency and the conversion of a real phase step into the delay that puts new-reference pulses back onto the feedback phase. It also covers dropping an edge while another is in flight, saturation with the delay left intact, and cancellation by a clear in the middle of a switch.

// File: rtl/pstep_pkg.sv
// Shared types for the phase-step absorbing delay.
package pstep_pkg;
    parameter int TICK_W = 12;
    typedef logic [TICK_W-1:0] tick_t;
    typedef enum logic [1:0] {M_IDLE, M_ARM, M_MEAS, M_HOLD} meter_st_e;
endpackage

// File: rtl/pstep_edge_det.sv
// Rising-edge detector for one clk-synchronous pulse input.
// Assumes the input is already synchronous to clk.
module pstep_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    output logic rise
);
    logic sig_q;

    // Remember the previous sample.
    always_ff @(posedge clk) begin
        if (!rst_n) sig_q <= 1'b0;
        else        sig_q <= sig_in;
    end

    assign rise = sig_in & ~sig_q;

    // R4: a detected edge never lasts two cycles
    a_r4_edge_single: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/pstep_delay_line.sv
// Delays one edge by dly ticks (plus one register stage); one edge in flight.
// Assumes dly is below the reference period, so regular edges never collide.
module pstep_delay_line
    import pstep_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  in_edge,
    input  tick_t dly,
    output logic  out_pulse
);
    logic  busy;
    tick_t cnt;

    // Accept an edge when idle, count down, fire a one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            cnt       <= '0;
            out_pulse <= 1'b0;
        end else begin
            out_pulse <= 1'b0;
            if (busy) begin
                if (cnt == tick_t'(1)) begin
                    out_pulse <= 1'b1;
                    busy      <= 1'b0;
                end else begin
                    cnt <= cnt - tick_t'(1);
                end
            end else if (in_edge) begin
                if (dly == '0) begin
                    out_pulse <= 1'b1;
                end else begin
                    busy <= 1'b1;
                    cnt  <= dly;
                end
            end
        end
    end

    // R3: output pulses are single-cycle
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_pulse |=> !out_pulse);
    // R10: while counting with more than one tick left, nothing fires
    a_r10_no_early_fire: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt != tick_t'(1)) |=> !out_pulse);
endmodule

// File: rtl/pstep_phase_meter.sv
// On a reference switch, measures ticks from a feedback edge to the new
// reference edge and offers the aligning delay once holdover is released.
// Assumes per is stable between resets.
module pstep_phase_meter
    import pstep_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clr,
    input  logic  en,
    input  logic  sel,
    input  logic  holdover,
    input  logic  fb_edge,
    input  logic  ref_edge,
    input  tick_t per,
    output logic  commit,
    output tick_t new_delay,
    output logic  err
);
    meter_st_e st;
    logic      sel_q;
    tick_t     m;
    tick_t     lag;
    logic      switched;

    assign switched = (sel != sel_q);

    // Measurement sequence: arm on switch, count, hold until holdover drops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= M_IDLE;
            sel_q <= sel;
            m     <= '0;
            lag   <= '0;
            err   <= 1'b0;
        end else begin
            sel_q <= sel;
            if (clr) begin
                st  <= M_IDLE;
                err <= 1'b0;
            end else if (switched && en) begin
                st  <= M_ARM;
                err <= 1'b0;
            end else begin
                case (st)
                    M_ARM: if (fb_edge) begin
                        if (ref_edge) begin
                            lag <= '0;
                            st  <= M_HOLD;
                        end else begin
                            m  <= tick_t'(1);
                            st <= M_MEAS;
                        end
                    end
                    M_MEAS: if (ref_edge) begin
                        lag <= m;
                        st  <= M_HOLD;
                    end else if (m == per - tick_t'(1)) begin
                        err <= 1'b1;
                        st  <= M_IDLE;
                    end else begin
                        m <= m + tick_t'(1);
                    end
                    M_HOLD: if (!holdover) st <= M_IDLE;
                    default: st <= M_IDLE;
                endcase
            end
        end
    end

    // Lag converted to the delay that lands the new edge on the feedback phase.
    assign new_delay = (lag == '0) ? '0 : per - lag;
    assign commit    = (st == M_HOLD) && !holdover && !clr && !(switched && en);

    // R7: an error can only come out of an active measurement
    a_r7_err_from_meas: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> $past(st == M_MEAS));
endmodule

// File: rtl/phase_step_absorber.sv
// Virtual-reference generator that absorbs phase steps on a reference switch.
// Assumes both references and the feedback are clk-synchronous pulses of the
// same rate, and that a reset follows every freq_sel change.
module phase_step_absorber
    import pstep_pkg::*;
#(
    parameter int PER_CODE0 = 20,
    parameter int PER_CODE1 = 200,
    parameter int PER_CODE2 = 50,
    parameter int PER_CODE3 = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_sel,
    input  logic              pri_ref,
    input  logic              sec_ref,
    input  logic              fb_pulse,
    input  logic              tie_en,
    input  logic              holdover,
    input  logic [1:0]        freq_sel,
    input  logic              delay_clr,
    output logic              vref_pulse,
    output logic [TICK_W-1:0] delay_val,
    output logic              meas_err
);
    localparam int NUM_IN = 3;

    logic [NUM_IN-1:0] raw_in;
    logic [NUM_IN-1:0] edge_v;
    tick_t             per;
    tick_t             delay_q;
    tick_t             eff_delay;
    tick_t             new_delay;
    logic              commit;
    logic              sel_edge;

    assign raw_in = {fb_pulse, sec_ref, pri_ref};

    // One edge detector per pulse input.
    for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_edge
        pstep_edge_det u_det (
            .clk    (clk),
            .rst_n  (rst_n),
            .sig_in (raw_in[gi]),
            .rise   (edge_v[gi])
        );
    end

    // Reference period in ticks for the rate code.
    always_comb begin
        case (freq_sel)
            2'b00:   per = tick_t'(PER_CODE0);
            2'b01:   per = tick_t'(PER_CODE1);
            2'b10:   per = tick_t'(PER_CODE2);
            default: per = tick_t'(PER_CODE3);
        endcase
    end

    assign sel_edge = ref_sel ? edge_v[1] : edge_v[0];

    pstep_phase_meter u_meter (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (delay_clr),
        .en        (tie_en),
        .sel       (ref_sel),
        .holdover  (holdover),
        .fb_edge   (edge_v[2]),
        .ref_edge  (sel_edge),
        .per       (per),
        .commit    (commit),
        .new_delay (new_delay),
        .err       (meas_err)
    );

    // Programmed delay: cleared, or loaded from the meter.
    always_ff @(posedge clk) begin
        if (!rst_n || delay_clr) delay_q <= '0;
        else if (commit)         delay_q <= new_delay;
    end

    assign eff_delay = tie_en ? delay_q : '0;
    assign delay_val = eff_delay;

    pstep_delay_line u_dly (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_edge   (sel_edge),
        .dly       (eff_delay),
        .out_pulse (vref_pulse)
    );

    // R8: clear zeroes the delay on the next cycle
    a_r8_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        delay_clr |=> (delay_q == '0));
    // R9: delay stays below the reference period
    a_r9_below_period: assert property (@(posedge clk) disable iff (!rst_n)
        delay_q < per);
    // R6: delay changes only after a clear or with holdover low
    a_r6_change_needs_release: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(delay_q) |-> ($past(delay_clr) || !$past(holdover)));
endmodule

// File: tb/phase_step_absorber_bench.sv
module phase_step_absorber_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_sel = 1'b0;
    logic        pri_ref = 1'b0;
    logic        sec_ref = 1'b0;
    logic        fb_pulse = 1'b0;
    logic        tie_en = 1'b0;
    logic        holdover = 1'b0;
    logic [1:0]  freq_sel = 2'b00;
    logic        delay_clr = 1'b0;
    logic        vref_pulse;
    logic [11:0] delay_val;
    logic        meas_err;

    int nchk = 0, nfail = 0, nmatch = 0, cyc = 0;
    int per = 20, pri_ph = 3, sec_ph = 10, fb_ph = 3, exp_d = 0;
    int extra_at = -1, chk_start = 0;
    bit gen_pri = 0, gen_sec = 0, gen_fb = 0;
    bit chk_on = 0, chk_arm = 0, align_on = 0;
    string cur_req = "R2";
    int q[$];

    phase_step_absorber u_phase_step_absorber (
        .clk(clk), .rst_n(rst_n), .ref_sel(ref_sel), .pri_ref(pri_ref),
        .sec_ref(sec_ref), .fb_pulse(fb_pulse), .tie_en(tie_en),
        .holdover(holdover), .freq_sel(freq_sel), .delay_clr(delay_clr),
        .vref_pulse(vref_pulse), .delay_val(delay_val), .meas_err(meas_err)
    );

    initial forever #10 clk = ~clk;
    initial forever begin @(posedge clk); cyc = cyc + 1; end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic stop_check();
        chk_on = 0; chk_arm = 0; align_on = 0;
        q.delete();
    endtask

    // Monitor then driver, both at the falling edge.
    initial forever begin
        bit sp;
        @(negedge clk);
        if (vref_pulse && chk_on && cyc > chk_start) begin
            if (q.size() == 0) check(0, {cur_req, " unexpected pulse"}, cyc, -1);
            else begin
                int e;
                e = q.pop_front();
                check(cyc == e, cur_req, cyc, e);
                if (cyc == e) nmatch++;
                if (align_on) check(((cyc - 1 - fb_ph) % per) == 0, "R11 align", (cyc - 1) % per, fb_ph);
            end
        end
        pri_ref  = gen_pri && ((cyc % per) == pri_ph);
        sec_ref  = (gen_sec && ((cyc % per) == sec_ph)) || (cyc == extra_at);
        fb_pulse = gen_fb && ((cyc % per) == fb_ph);
        sp = ref_sel ? (gen_sec && ((cyc % per) == sec_ph)) : pri_ref;
        if (sp && chk_arm) begin chk_start = cyc; chk_on = 1; chk_arm = 0; end
        if (sp && chk_on) q.push_back(cyc + 1 + exp_d);
    end

    initial begin
        #4ms;
        nchk++; nfail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        step(4);
        rst_n = 1;
        step(1);
        // R1 reset state
        check(vref_pulse == 0, "R1 vref", vref_pulse, 0);
        check(delay_val == 0, "R1 delay", delay_val, 0);
        check(meas_err == 0, "R1 err", meas_err, 0);

        // R2 / R4: disabled, primary selected, secondary on another phase
        gen_pri = 1; gen_sec = 1; gen_fb = 1;
        exp_d = 0; cur_req = "R2"; chk_arm = 1; align_on = 1;
        step(100);
        check(delay_val == 0, "R2 delay", delay_val, 0);
        check(nmatch >= 4, "R4 primary only", nmatch, 4);
        stop_check();

        // R6 / R5: switch to secondary with a 7-tick step under holdover
        tie_en = 1; holdover = 1; ref_sel = 1;
        step(60);
        check(delay_val == 0, "R6 held", delay_val, 0);
        check(meas_err == 0, "R5 no err", meas_err, 0);
        holdover = 0;
        step(3);
        check(delay_val == 13, "R5 delay", delay_val, 13);

        // R3 / R11: delayed pulses land on the feedback phase
        exp_d = 13; cur_req = "R3"; nmatch = 0; chk_arm = 1; align_on = 1;
        step(100);
        check(nmatch >= 4, "R3 pulses seen", nmatch, 4);

        // R10: extra edge while one is in flight is dropped
        cur_req = "R10"; nmatch = 0;
        extra_at = ((cyc / per) + 2) * per + sec_ph + 5;
        step(100);
        check(nmatch >= 4, "R10 stream intact", nmatch, 4);
        stop_check(); extra_at = -1;

        // R7: switch to a silent primary -> timeout, delay kept
        gen_pri = 0; holdover = 1; ref_sel = 0;
        step(60);
        check(meas_err == 1, "R7 err set", meas_err, 1);
        holdover = 0;
        step(3);
        check(delay_val == 13, "R7 delay kept", delay_val, 13);

        // R8: clear zeroes delay and error
        delay_clr = 1; step(1); delay_clr = 0;
        check(delay_val == 0, "R8 cleared", delay_val, 0);
        check(meas_err == 0, "R7 err cleared", meas_err, 0);

        // R8: clear cancels a finished measurement waiting for release
        gen_pri = 1; holdover = 1; ref_sel = 1;
        step(60);
        delay_clr = 1; step(1); delay_clr = 0;
        holdover = 0;
        step(5);
        check(delay_val == 0, "R8 abort", delay_val, 0);

        // R9: rate code 10 -> period 50, step of 30 ticks
        rst_n = 0; freq_sel = 2'b10; per = 50; ref_sel = 0;
        pri_ph = 3; fb_ph = 3; sec_ph = 33; holdover = 1;
        step(4);
        rst_n = 1;
        step(2);
        check(delay_val == 0, "R1 after reset", delay_val, 0);
        ref_sel = 1;
        step(150);
        check(delay_val == 0, "R6 held", delay_val, 0);
        holdover = 0;
        step(3);
        check(delay_val == 20, "R9 delay", delay_val, 20);
        exp_d = 20; cur_req = "R9"; nmatch = 0; chk_arm = 1; align_on = 1;
        step(300);
        check(nmatch >= 4, "R9 pulses seen", nmatch, 4);
        stop_check();

        // R2: disabling restores zero added delay
        tie_en = 0; exp_d = 0; cur_req = "R2"; nmatch = 0;
        step(1);
        check(delay_val == 0, "R2 disabled delay", delay_val, 0);
        chk_arm = 1;
        step(200);
        check(nmatch >= 3, "R2 pulses seen", nmatch, 3);
        stop_check();

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule